// File: doc/BRIEF.md
# Clock-Data Skew Compensator

This block sits on the receive side of a synchronous serial link in which the clock and the data travel as two separate line channels. Both lines are sampled by a local clock running at eight times the transmission clock. During a training interval it works out which line arrives first and by how many oversample ticks, then delays the earlier line by that amount so the two channels line up again. One data bit is carried per transmission clock period.

Training is started by raising a calibration enable while the far end sends a pattern that toggles the data line once per period, with the clock line running. Eight lag measurements are taken and their lower median becomes the frozen setting. If a line goes silent during training, an overflow flag is raised and the old setting is kept. Outside training, the realigned clock and data pair is driven out, and each bit is sampled halfway through its aligned period and presented with a one-cycle valid strobe.

Top module: `skew_comp`

## Requirements
- R1: After a synchronous reset `skew_amt_o` is 0, `data_first_o` is 0 (no compensation), and `cal_done_o`, `skew_ovf_o` and `bit_vld_o` are 0.
- R2: Training starts only on a 0-to-1 change of `cal_en_i`, and measurements are taken only while it stays high; line activity with `cal_en_i` low leaves `skew_amt_o`, `data_first_o` and `cal_done_o` unchanged.
- R3: A measurement pairs the first clock rising edge or data transition seen after the previous pair with the next event of the other kind; the lag is their distance in ticks (0 to 7), and two events in the same tick give lag 0.
- R4: After eight measurements the setting is the lower median (fourth smallest) of the eight signed lags, `cal_done_o` goes to 1, and the setting stays frozen until the next training.
- R5: The signed lag is positive when the data line is early; `data_first_o` is 1 when the median is positive and `skew_amt_o` is the magnitude of the median.
- R6: If eight ticks pass after a first event without the partner event, `skew_ovf_o` goes to 1, training stops with `cal_done_o` at 0 and the setting unchanged; the flag clears when the next training starts.
- R7: The early line is delayed by `skew_amt_o` ticks (the data line when `data_first_o` is 1, else the clock line) on its way to the aligned outputs; the other line is not delayed.
- R8: `bit_o` takes the aligned data value four ticks after each aligned clock rising edge, with `bit_vld_o` high for one cycle, so one bit per transmission period comes out in arrival order.
- R9: Each line passes through a two-flop synchronizer and one register of equal depth on both channels, so a line change reaches its undelayed aligned output three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, eight ticks per transmission period |
| rst | input | 1 | Synchronous reset, active high |
| cal_en_i | input | 1 | Training enable; a rising edge starts a calibration |
| line_clk_i | input | 1 | Asynchronous transmission clock line |
| line_dat_i | input | 1 | Asynchronous data line |
| aligned_clk_o | output | 1 | Clock line after skew removal |
| aligned_dat_o | output | 1 | Data line after skew removal |
| bit_o | output | 1 | Recovered data bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a new `bit_o` |
| skew_amt_o | output | 3 | Applied delay in ticks |
| data_first_o | output | 1 | 1 when the data line is the delayed (early) one |
| cal_done_o | output | 1 | Training completed with a new setting |
| skew_ovf_o | output | 1 | Training aborted because a partner edge never came |

## Verification
A line change reaches its aligned output three edges later plus the applied delay, so the bench flips one line at a time and counts falling-edge samples until the output moves, expecting exactly that count. The calibration result is committed one tick after the eighth pair, at most about seventy ticks into a ten-period pattern, and the bench reads the setting only after the pattern plus a twelve-tick quiet gap. A recovered bit is due five edges after its aligned clock rise; rather than pin each strobe to a cycle, the bench gathers strobes while a bit run is driven and compares the count and order against the driven byte once the run has drained.

// File: rtl/skcomp_pkg.sv
package skcomp_pkg;

    // Default geometry: oversample ticks per transmission period and
    // number of lag measurements folded into one setting.
    localparam int unsigned TICKS = 8;
    localparam int unsigned NMEAS = 8;
    localparam int unsigned SKW   = $clog2(TICKS);
    localparam int unsigned LAGW  = SKW + 1;

    // Pair-measurement state: waiting for a first event, or counting
    // ticks until the partner event shows up.
    typedef enum logic [0:0] {
        MS_IDLE,
        MS_WAIT
    } meas_st_e;

    // Delay setting applied to the early line.
    typedef struct packed {
        logic           dat_first;
        logic [SKW-1:0] amt;
    } skew_set_t;

    // Signed lag (positive: data early) to a delay setting.
    function automatic skew_set_t lag_to_set(input logic signed [LAGW-1:0] lag);
        skew_set_t s;
        s.dat_first = (lag > 0);
        s.amt       = (lag < 0) ? SKW'(-lag) : SKW'(lag);
        return s;
    endfunction

endpackage

// File: rtl/skc_line.sv
// One line channel: two-flop synchronizer then a tap shift register.
// tap_o[k] is the synchronized line value k ticks older than tap_o[0].
module skc_line #(
    parameter int unsigned TAPS = skcomp_pkg::TICKS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_i,
    output logic [TAPS-1:0] tap_o
);

    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            tap_o  <= '0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            tap_o  <= {tap_o[TAPS-2:0], sync_q};
        end
    end

endmodule

// File: rtl/skc_meter.sv
// Training: pairs clock rises with data transitions, stores signed lags,
// and commits the lower median as the frozen delay setting.
module skc_meter #(
    parameter int unsigned TICKS = skcomp_pkg::TICKS,
    parameter int unsigned NMEAS = skcomp_pkg::NMEAS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cal_en_i,
    input  logic                  clk_rise_i,
    input  logic                  dat_edge_i,
    output skcomp_pkg::skew_set_t set_o,
    output logic                  done_o,
    output logic                  ovf_o
);

    localparam int unsigned CW = $clog2(TICKS);
    localparam int unsigned LW = CW + 1;
    localparam int unsigned IW = $clog2(NMEAS);
    localparam int unsigned NW = $clog2(NMEAS + 1);

    skcomp_pkg::meas_st_e st_q;
    logic                 cal_q;
    logic                 run_q;
    logic                 lead_dat_q;
    logic [CW-1:0]        cnt_q;
    logic [NW-1:0]        n_q;
    logic signed [LW-1:0] lag_q [NMEAS];

    logic                 start;
    logic                 meas_ok;
    logic                 meas_ovf;
    logic signed [LW-1:0] meas_val;
    logic signed [LW-1:0] mag;
    logic signed [LW-1:0] med;

    assign start = cal_en_i & ~cal_q;
    assign mag   = $signed({1'b0, cnt_q});

    // Pair completion and timeout detection.
    always_comb begin
        meas_ok  = 1'b0;
        meas_ovf = 1'b0;
        meas_val = '0;
        if (run_q && cal_en_i && (n_q != NW'(NMEAS))) begin
            if (st_q == skcomp_pkg::MS_IDLE) begin
                if (clk_rise_i && dat_edge_i) begin
                    meas_ok = 1'b1;
                end
            end else if (lead_dat_q ? clk_rise_i : dat_edge_i) begin
                meas_ok  = 1'b1;
                meas_val = lead_dat_q ? mag : -mag;
            end else if (cnt_q == CW'(TICKS - 1)) begin
                meas_ovf = 1'b1;
            end
        end
    end

    // Lower median by rank counting: smallest value with at least
    // NMEAS/2 entries less than or equal to it.
    always_comb begin
        logic found;
        found = 1'b0;
        med   = '0;
        for (int i = 0; i < NMEAS; i++) begin
            int unsigned le;
            le = 0;
            for (int j = 0; j < NMEAS; j++) begin
                if (lag_q[j] <= lag_q[i]) le++;
            end
            if ((le >= NMEAS / 2) && (!found || (lag_q[i] < med))) begin
                med   = lag_q[i];
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= skcomp_pkg::MS_IDLE;
            cal_q      <= 1'b0;
            run_q      <= 1'b0;
            lead_dat_q <= 1'b0;
            cnt_q      <= '0;
            n_q        <= '0;
            set_o      <= '0;
            done_o     <= 1'b0;
            ovf_o      <= 1'b0;
            for (int i = 0; i < NMEAS; i++) lag_q[i] <= '0;
        end else begin
            cal_q <= cal_en_i;
            if (start) begin
                run_q  <= 1'b1;
                n_q    <= '0;
                st_q   <= skcomp_pkg::MS_IDLE;
                done_o <= 1'b0;
                ovf_o  <= 1'b0;
            end else if (run_q) begin
                if (!cal_en_i) begin
                    run_q <= 1'b0;
                    st_q  <= skcomp_pkg::MS_IDLE;
                end else if (n_q == NW'(NMEAS)) begin
                    set_o  <= skcomp_pkg::lag_to_set(med);
                    done_o <= 1'b1;
                    run_q  <= 1'b0;
                end else if (meas_ok) begin
                    lag_q[n_q[IW-1:0]] <= meas_val;
                    n_q                <= n_q + NW'(1);
                    st_q               <= skcomp_pkg::MS_IDLE;
                end else if (meas_ovf) begin
                    ovf_o <= 1'b1;
                    run_q <= 1'b0;
                    st_q  <= skcomp_pkg::MS_IDLE;
                end else if (st_q == skcomp_pkg::MS_WAIT) begin
                    cnt_q <= cnt_q + CW'(1);
                end else if (clk_rise_i || dat_edge_i) begin
                    st_q       <= skcomp_pkg::MS_WAIT;
                    lead_dat_q <= dat_edge_i;
                    cnt_q      <= CW'(1);
                end
            end
        end
    end

    // R6: a timeout never disturbs the applied setting.
    a_r6_ovf_keeps_setting: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $stable(set_o));

    // R6: an aborted training never reports completion.
    a_r6_done_ovf_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && ovf_o));

    // R4: completion only after the full set of measurements.
    a_r4_done_after_full: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(n_q) == NW'(NMEAS)));

    // R2: no measurement is stored outside a running training.
    a_r2_no_store_idle: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !start) |=> $stable(n_q));

endmodule

// File: rtl/skc_bit.sv
// Recovers one bit per period: samples aligned data at the middle of the
// aligned period, counted from each aligned clock rising edge.
module skc_bit #(
    parameter int unsigned TICKS = skcomp_pkg::TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic aclk_i,
    input  logic adat_i,
    output logic bit_o,
    output logic vld_o
);

    localparam int unsigned PW  = $clog2(TICKS);
    localparam int unsigned MID = TICKS / 2;

    logic          prev_q;
    logic          active_q;
    logic [PW-1:0] ph_q;
    logic          rise;

    assign rise = aclk_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            active_q <= 1'b0;
            ph_q     <= '0;
            bit_o    <= 1'b0;
            vld_o    <= 1'b0;
        end else begin
            prev_q <= aclk_i;
            vld_o  <= 1'b0;
            if (rise) begin
                active_q <= 1'b1;
                ph_q     <= PW'(1);
            end else if (active_q) begin
                if (ph_q == PW'(MID)) begin
                    bit_o    <= adat_i;
                    vld_o    <= 1'b1;
                    active_q <= 1'b0;
                end else begin
                    ph_q <= ph_q + PW'(1);
                end
            end
        end
    end

    // R8: the strobe lasts a single cycle.
    a_r8_vld_single: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);

    // R8: a strobe is always preceded by an armed sampling window.
    a_r8_vld_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(vld_o) |-> $past(active_q));

endmodule

// File: rtl/skew_comp.sv
module skew_comp #(
    parameter int unsigned TICKS = skcomp_pkg::TICKS,
    parameter int unsigned NMEAS = skcomp_pkg::NMEAS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cal_en_i,
    input  logic                        line_clk_i,
    input  logic                        line_dat_i,
    output logic                        aligned_clk_o,
    output logic                        aligned_dat_o,
    output logic                        bit_o,
    output logic                        bit_vld_o,
    output logic [skcomp_pkg::SKW-1:0]  skew_amt_o,
    output logic                        data_first_o,
    output logic                        cal_done_o,
    output logic                        skew_ovf_o
);

    localparam int unsigned NCH = 2;  // channel 0: clock line, 1: data line

    logic [NCH-1:0]        line_in;
    logic [TICKS-1:0]      taps [NCH];
    skcomp_pkg::skew_set_t set;
    logic                  clk_rise;
    logic                  dat_edge;

    assign line_in = {line_dat_i, line_clk_i};

    for (genvar c = 0; c < NCH; c++) begin : g_line
        skc_line #(.TAPS(TICKS)) u_line (
            .clk    (clk),
            .rst    (rst),
            .line_i (line_in[c]),
            .tap_o  (taps[c])
        );
    end

    assign clk_rise = taps[0][0] & ~taps[0][1];
    assign dat_edge = taps[1][0] ^ taps[1][1];

    skc_meter #(.TICKS(TICKS), .NMEAS(NMEAS)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .cal_en_i   (cal_en_i),
        .clk_rise_i (clk_rise),
        .dat_edge_i (dat_edge),
        .set_o      (set),
        .done_o     (cal_done_o),
        .ovf_o      (skew_ovf_o)
    );

    // Only the early line goes through its delay taps.
    assign aligned_clk_o = set.dat_first ? taps[0][0] : taps[0][set.amt];
    assign aligned_dat_o = set.dat_first ? taps[1][set.amt] : taps[1][0];

    skc_bit #(.TICKS(TICKS)) u_bit (
        .clk    (clk),
        .rst    (rst),
        .aclk_i (aligned_clk_o),
        .adat_i (aligned_dat_o),
        .bit_o  (bit_o),
        .vld_o  (bit_vld_o)
    );

    assign skew_amt_o   = set.amt;
    assign data_first_o = set.dat_first;

    // R7: with data early, the clock output follows the undelayed clock tap.
    a_r7_late_line_direct: assert property (@(posedge clk) disable iff (rst)
        (data_first_o && $stable(data_first_o)) |-> (aligned_clk_o == taps[0][0]));

endmodule

// File: tb/test_skew_comp.sv
module test_skew_comp;

    typedef struct packed {
        logic [2:0]      cc;    // clock rise offset within a period
        logic [7:0][2:0] e;     // data change offset, per period
        logic [2:0]      amt;   // expected delay
        logic            df;    // expected data-early flag
        logic [7:0]      bits;  // bit run, bit p sent in period p
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, {8{3'd3}}, 3'd3, 1'b0, 8'hA5},
        '{3'd5, {8{3'd0}}, 3'd5, 1'b1, 8'h3C},
        '{3'd2, {8{3'd2}}, 3'd0, 1'b0, 8'hF0},
        '{3'd7, {8{3'd0}}, 3'd7, 1'b1, 8'h96},
        '{3'd0, {8{3'd7}}, 3'd7, 1'b0, 8'h0F},
        '{3'd4, {3'd0,3'd1,3'd7,3'd1,3'd2,3'd6,3'd1,3'd1}, 3'd3, 1'b1, 8'h5A},
        '{3'd0, {3'd2,3'd2,3'd1,3'd6,3'd2,3'd2,3'd5,3'd2}, 3'd2, 1'b0, 8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_en_i = 1'b0;
    logic       line_clk_i = 1'b0;
    logic       line_dat_i = 1'b0;
    logic       aligned_clk_o, aligned_dat_o, bit_o, bit_vld_o;
    logic [2:0] skew_amt_o;
    logic       data_first_o, cal_done_o, skew_ovf_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    bit   mon_en = 1'b0;
    int   ngot = 0;
    logic [7:0] got_bits = '0;

    always #10 clk = ~clk;

    skew_comp i_skew_comp (
        .clk           (clk),
        .rst           (rst),
        .cal_en_i      (cal_en_i),
        .line_clk_i    (line_clk_i),
        .line_dat_i    (line_dat_i),
        .aligned_clk_o (aligned_clk_o),
        .aligned_dat_o (aligned_dat_o),
        .bit_o         (bit_o),
        .bit_vld_o     (bit_vld_o),
        .skew_amt_o    (skew_amt_o),
        .data_first_o  (data_first_o),
        .cal_done_o    (cal_done_o),
        .skew_ovf_o    (skew_ovf_o)
    );

    always @(negedge clk) begin
        if (mon_en && bit_vld_o) begin
            if (ngot < 8) got_bits[ngot] = bit_o;
            ngot++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives nper periods; data changes once per period at its offset.
    // data_mode: data takes the bit run, else it toggles (training).
    task automatic drive(input vec_t v, input int nper, input bit data_mode, input bit data_on);
        for (int p = 0; p < nper; p++) begin
            for (int k = 0; k < 8; k++) begin
                int n;
                int cc;
                int ep;
                n  = 8 * p + k;
                cc = int'(v.cc);
                line_clk_i = (n >= cc) && (((n - cc) % 8) < 4);
                ep = (p < 8 && !data_mode) ? int'(v.e[p]) : int'(v.e[0]);
                if (data_on && k == ep) begin
                    if (data_mode) line_dat_i = v.bits[p % 8];
                    else line_dat_i = ~line_dat_i;
                end
                @(negedge clk);
            end
        end
        line_clk_i = 1'b0;
        @(negedge clk);
    endtask

    // Flips one line and counts falling edges until its aligned output moves.
    task automatic lat(input bit on_clk, output int n);
        logic old;
        old = on_clk ? aligned_clk_o : aligned_dat_o;
        if (on_clk) line_clk_i = ~line_clk_i;
        else line_dat_i = ~line_dat_i;
        n = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            n++;
            if ((on_clk ? aligned_clk_o : aligned_dat_o) != old) break;
        end
    endtask

    task automatic train(input vec_t v, input bit data_on);
        cal_en_i = 1'b1;
        ticks(4);
        drive(v, 10, 1'b0, data_on);
        ticks(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual expired expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        ticks(4);
        rst = 1'b0;
        ticks(1);
        // R1: reset state
        chk("R1 skew_amt after reset", skew_amt_o, 0);
        chk("R1 data_first after reset", data_first_o, 0);
        chk("R1 cal_done after reset", cal_done_o, 0);
        chk("R1 skew_ovf after reset", skew_ovf_o, 0);
        chk("R1 bit_vld after reset", bit_vld_o, 0);

        // R9: three-edge path on both lines with no compensation
        lat(1'b1, n);
        chk("R9 clock line latency", n, 3);
        lat(1'b0, n);
        chk("R9 data line latency", n, 3);
        line_clk_i = 1'b0;
        ticks(16);

        // Table walk: R3/R4/R5 training, R8 bit run, R7 delay placement
        for (int vi = 0; vi < NVEC; vi++) begin
            vec_t v;
            v = VEC[vi];
            train(v, 1'b1);
            chk($sformatf("R4 done vec%0d", vi), cal_done_o, 1);
            chk($sformatf("R3 R5 skew_amt vec%0d", vi), skew_amt_o, int'(v.amt));
            chk($sformatf("R5 data_first vec%0d", vi), data_first_o, int'(v.df));
            chk($sformatf("R6 no overflow vec%0d", vi), skew_ovf_o, 0);
            cal_en_i = 1'b0;
            ticks(2);
            ngot = 0;
            got_bits = '0;
            mon_en = 1'b1;
            drive(v, 8, 1'b1, 1'b1);
            ticks(12);
            mon_en = 1'b0;
            chk($sformatf("R8 bit count vec%0d", vi), ngot, 8);
            chk($sformatf("R8 bit run vec%0d", vi), int'(got_bits), int'(v.bits));
            lat(1'b0, n);
            chk($sformatf("R7 data path delay vec%0d", vi), n, 3 + (v.df ? int'(v.amt) : 0));
            lat(1'b1, n);
            chk($sformatf("R7 clock path delay vec%0d", vi), n, 3 + (v.df ? 0 : int'(v.amt)));
            line_clk_i = 1'b0;
            ticks(16);
        end

        // R6: data line silent during training
        train(VEC[0], 1'b0);
        chk("R6 overflow raised", skew_ovf_o, 1);
        chk("R6 done stays low", cal_done_o, 0);
        chk("R6 amt kept", skew_amt_o, 2);
        chk("R6 direction kept", data_first_o, 0);
        cal_en_i = 1'b0;
        ticks(4);

        // R2: training pattern with enable low has no effect
        drive(VEC[4], 10, 1'b0, 1'b1);
        ticks(12);
        chk("R2 amt unchanged", skew_amt_o, 2);
        chk("R2 direction unchanged", data_first_o, 0);
        chk("R2 done unchanged", cal_done_o, 0);

        // R6: next training clears the flag
        train(VEC[1], 1'b1);
        chk("R6 overflow cleared", skew_ovf_o, 0);
        chk("R4 done after retrain", cal_done_o, 1);
        chk("R5 amt after retrain", skew_amt_o, 5);
        cal_en_i = 1'b0;
        ticks(2);

        // R1: reset clears a live setting
        rst = 1'b1;
        ticks(2);
        rst = 1'b0;
        ticks(1);
        chk("R1 amt cleared", skew_amt_o, 0);
        chk("R1 direction cleared", data_first_o, 0);
        chk("R1 done cleared", cal_done_o, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule